// File: doc/BRIEF.md
# Polar Return-to-Zero Line Codec

This block turns a serial NRZ data stream into a three-level polar line symbol and turns such a symbol stream back into data, a recovered bit clock and a per-bit valid strobe. The system clock runs at twice the bit rate. Each bit cell therefore has a high half (the gate is open) and a low half. On the transmit side, true and inverted data are gated with the bit clock onto two rails. The rails are packed into a signed 2-bit symbol. The `nrz_mode` input holds the gate open, which turns the return-to-zero polar output into non-return-to-zero polar. The receive side decodes the sign of the incoming symbol into data and its magnitude into a clock. It uses the block's own phase to mark when each bit is complete.

A small phase state machine drives the timing. It has three states: ST_IDLE is held during reset, ST_MARK is the high half-cell and ST_SPACE is the low half-cell. The transitions are:

- IDLE_TO_MARK on the first edge after reset.
- MARK_TO_SPACE on every edge in ST_MARK.
- SPACE_TO_MARK on every edge in ST_SPACE.

A new data bit is loaded on each edge that enters ST_MARK. In a loopback system the transmit symbol is wired straight back to the receive input.

Top module: `polar_rz_codec`

## Requirements
- R1: After reset is released, `bit_clk` is 1 in the first cycle (ST_MARK) and then alternates every system clock; it is 1 exactly in high half-cells.
- R2: `rail_pos` and `rail_neg` are never 1 together; in a high half-cell `rail_pos` is 1 for a data bit of 1 and `rail_neg` is 1 for a data bit of 0.
- R3: `tx_symbol` encodes +1 as 2'b01, −1 as 2'b11 and zero as 2'b00; with `nrz_mode` = 0 the symbol is 2'b00 in every low half-cell.
- R4: `tx_data` is sampled only on the edge that starts a high half-cell (while `bit_clk` is 0); changes to it during a high half-cell have no effect on that bit.
- R5: With `nrz_mode` = 1 the symbol keeps the bit's ±1 value in both halves of the cell.
- R6: One cycle after `rx_symbol` is 2'b01, `rx_data` is 1 and `rx_clk` is 1; one cycle after 2'b11, `rx_data` is 0 and `rx_clk` is 1; one cycle after 2'b00 or 2'b10, both are 0.
- R7: `rx_valid` is a one-cycle pulse in the cycle after every high half-cell; in loopback, `rx_data` then equals the bit sent in that cell.
- R8: In loopback with `nrz_mode` = 1, `rx_clk` stays 1 from the first valid bit onward; with `nrz_mode` = 0 it is 0 in high half-cells and 1 in low half-cells.
- R9: While `rst` is 1 (synchronous, active high), `bit_clk`, both rails, `tx_symbol`, `rx_data`, `rx_clk` and `rx_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| nrz_mode | input | 1 | 1 holds the gate open (NRZ polar), 0 gives RZ polar |
| tx_data | input | 1 | Serial NRZ data to send |
| bit_clk | output | 1 | Bit clock, high in the first half of each cell |
| rail_pos | output | 1 | Positive rail |
| rail_neg | output | 1 | Negative rail |
| tx_symbol | output | 2 | Signed polar symbol sent on the line |
| rx_symbol | input | 2 | Signed polar symbol received from the line |
| rx_data | output | 1 | Recovered data (sign of the symbol) |
| rx_clk | output | 1 | Recovered clock (magnitude of the symbol) |
| rx_valid | output | 1 | One-cycle strobe marking a complete received bit |

## Verification
A scoreboard sends four patterns in each mode, with the symbol looped back:

- All ones shows that only the positive rail is used.
- All zeros shows that only the negative rail is used.
- Alternating bits exposes a stale hold or a swapped rail, because each bit differs from the one before.
- A random stream catches errors that depend on the data.

During every high half-cell the bench drives inverted data, so that sampling at the wrong edge shows up as a corrupted symbol. Running the same patterns in both modes separates the zero level in the low half-cell from the held level. Directed symbols injected on the receive input, including the unused code 2'b10, cover decoding that loopback cannot produce.

// File: rtl/polar_codec_pkg.sv
package polar_codec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MARK  = 2'd1,
        ST_SPACE = 2'd2
    } phase_e;

    localparam int SYM_W = 2;
    localparam logic [SYM_W-1:0] SYM_ZERO = 2'b00;
    localparam logic [SYM_W-1:0] SYM_POS  = 2'b01;
    localparam logic [SYM_W-1:0] SYM_NEG  = 2'b11;
endpackage

// File: rtl/polar_phase_fsm.sv
module polar_phase_fsm
    import polar_codec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output phase_e state,
    output logic   bit_clk,
    output logic   load
);
    phase_e st_q;
    phase_e st_d;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  st_d = ST_MARK;   // IDLE_TO_MARK
            ST_MARK:  st_d = ST_SPACE;  // MARK_TO_SPACE
            ST_SPACE: st_d = ST_MARK;   // SPACE_TO_MARK
            default:  st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // outputs
    always_comb begin
        state   = st_q;
        bit_clk = (st_q == ST_MARK);
        load    = (st_q != ST_MARK);
    end

    p_idle_leaves_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |=> (st_q == ST_MARK));
    p_mark_to_space_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_MARK) |=> (st_q == ST_SPACE));
    p_space_to_mark_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SPACE) |=> (st_q == ST_MARK));
endmodule

// File: rtl/polar_encoder.sv
module polar_encoder (
    input  logic clk,
    input  logic rst,
    input  logic nrz_mode,
    input  logic load,
    input  logic tx_data,
    output logic rail_pos,
    output logic rail_neg
);
    logic hold_q;
    logic bit_d;
    logic gate_d;

    always_comb begin
        bit_d  = load ? tx_data : hold_q;
        gate_d = load | nrz_mode;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= 1'b0;
            rail_pos <= 1'b0;
            rail_neg <= 1'b0;
        end else begin
            if (load) hold_q <= tx_data;
            rail_pos <= bit_d & gate_d;
            rail_neg <= ~bit_d & gate_d;
        end
    end

    p_rails_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        !(rail_pos && rail_neg));
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(hold_q));
    p_rz_gap_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !nrz_mode) |=> (!rail_pos && !rail_neg));
    p_nrz_level_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && nrz_mode) |=> (rail_pos || rail_neg));
endmodule

// File: rtl/polar_decoder.sv
module polar_decoder
    import polar_codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  phase_e           state,
    input  logic [SYM_W-1:0] rx_symbol,
    output logic             rx_data,
    output logic             rx_clk,
    output logic             rx_valid
);
    logic is_pos;
    logic is_mark;

    always_comb begin
        is_pos  = (rx_symbol == SYM_POS);
        is_mark = is_pos || (rx_symbol == SYM_NEG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= 1'b0;
            rx_clk   <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_data  <= is_pos;
            rx_clk   <= is_mark;
            rx_valid <= (state == ST_MARK);
        end
    end

    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
    p_data_needs_clk_r6: assert property (@(posedge clk) disable iff (rst)
        rx_data |-> rx_clk);
endmodule

// File: rtl/polar_rz_codec.sv
module polar_rz_codec
    import polar_codec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nrz_mode,
    input  logic             tx_data,
    output logic             bit_clk,
    output logic             rail_pos,
    output logic             rail_neg,
    output logic [SYM_W-1:0] tx_symbol,
    input  logic [SYM_W-1:0] rx_symbol,
    output logic             rx_data,
    output logic             rx_clk,
    output logic             rx_valid
);
    phase_e state;
    logic   load;

    polar_phase_fsm u_phase (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .bit_clk (bit_clk),
        .load    (load)
    );

    polar_encoder u_enc (
        .clk      (clk),
        .rst      (rst),
        .nrz_mode (nrz_mode),
        .load     (load),
        .tx_data  (tx_data),
        .rail_pos (rail_pos),
        .rail_neg (rail_neg)
    );

    // symbol = positive rail minus negative rail, two's complement
    assign tx_symbol = {rail_neg, rail_pos | rail_neg};

    polar_decoder u_dec (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .rx_symbol (rx_symbol),
        .rx_data   (rx_data),
        .rx_clk    (rx_clk),
        .rx_valid  (rx_valid)
    );

    p_symbol_zero_in_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> (tx_symbol == SYM_ZERO));
endmodule

// File: tb/tb_polar_rz_codec.sv
`timescale 1ns/1ps
module tb_polar_rz_codec;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nrz_mode = 1'b0;
    logic       tx_data = 1'b0;
    logic       bit_clk, rail_pos, rail_neg;
    logic [1:0] tx_symbol;
    logic [1:0] rx_symbol;
    logic       rx_data, rx_clk, rx_valid;
    logic       inject = 1'b0;
    logic [1:0] inject_val = 2'b00;

    int  checks = 0;
    int  errors = 0;
    int  cycles = 0;
    bit  running = 0;
    bit  seen_valid = 0;
    bit  cur_bit = 0;
    int  pattern = 0;
    int  bit_idx = 0;
    bit  exp_q[$];

    always #2 clk = ~clk;

    assign rx_symbol = inject ? inject_val : tx_symbol;

    polar_rz_codec dut (
        .clk(clk), .rst(rst), .nrz_mode(nrz_mode), .tx_data(tx_data),
        .bit_clk(bit_clk), .rail_pos(rail_pos), .rail_neg(rail_neg),
        .tx_symbol(tx_symbol), .rx_symbol(rx_symbol), .rx_data(rx_data),
        .rx_clk(rx_clk), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // driver: new bit in low half-cells, inverted junk in high half-cells (R4)
    task automatic drive();
        if (!bit_clk) begin
            bit b;
            case (pattern)
                0: b = 1'b1;
                1: b = 1'b0;
                2: b = bit_idx[0];
                default: b = 1'($urandom_range(0, 1));
            endcase
            bit_idx++;
            cur_bit = b;
            tx_data = b;
            exp_q.push_back(b);
            running = 1;
        end else begin
            tx_data = ~cur_bit;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && running && !inject) begin
            logic [1:0] exp_sym;
            exp_sym = cur_bit ? 2'b01 : 2'b11;
            chk(!(rail_pos && rail_neg), "R2 rails exclusive", {rail_pos, rail_neg}, 0);
            if (bit_clk) begin
                chk(tx_symbol == exp_sym, "R3 high half symbol", tx_symbol, exp_sym);
                chk(rail_pos == cur_bit, "R2 positive rail", rail_pos, cur_bit);
                chk(!rx_valid, "R7 no valid in high half", rx_valid, 0);
                if (!nrz_mode) begin
                    chk(!rx_clk, "R8 rz clock low", rx_clk, 0);
                    chk(!rx_data, "R6 zero decodes 0", rx_data, 0);
                end
            end else begin
                if (nrz_mode)
                    chk(tx_symbol == exp_sym, "R5 nrz held level R4", tx_symbol, exp_sym);
                else
                    chk(tx_symbol == 2'b00, "R3 rz low half zero", tx_symbol, 0);
                chk(rx_valid, "R7 valid pulse", rx_valid, 1);
                if (!nrz_mode) chk(rx_clk, "R8 rz clock high", rx_clk, 1);
                if (rx_valid && exp_q.size() > 0) begin
                    bit e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R7 loopback data", rx_data, e);
                end
            end
            if (nrz_mode && seen_valid)
                chk(rx_clk, "R8 nrz clock steady", rx_clk, 1);
            if (rx_valid) seen_valid = 1;
        end
    end

    // R1 phase alternation
    logic prev_bclk = 1'b0;
    always @(negedge clk) begin
        if (!rst && running && !inject)
            chk(bit_clk != prev_bclk, "R1 bit clock alternates", bit_clk, !prev_bclk);
        prev_bclk = rst ? 1'b0 : bit_clk;
    end

    task automatic do_reset(input bit mode);
        @(negedge clk);
        rst = 1'b1;
        running = 0;
        seen_valid = 0;
        exp_q.delete();
        nrz_mode = mode;
        repeat (3) @(negedge clk);
        chk(!bit_clk && !rail_pos && !rail_neg, "R9 reset tx", {bit_clk, rail_pos, rail_neg}, 0);
        chk(tx_symbol == 2'b00, "R9 reset symbol", tx_symbol, 0);
        chk(!rx_data && !rx_clk && !rx_valid, "R9 reset rx", {rx_data, rx_clk, rx_valid}, 0);
        rst = 1'b0;
    endtask

    task automatic run_stream(input bit mode, input int pat, input int nbits);
        pattern = pat;
        bit_idx = 0;
        do_reset(mode);
        #1;
        // R1: first cycle after release is the high half-cell
        for (int i = 0; i < 2 * nbits; i++) begin
            drive();
            @(negedge clk);
            if (i == 0) chk(bit_clk, "R1 first cycle high", bit_clk, 1);
            #1;
        end
    endtask

    task automatic inject_sym(input logic [1:0] s, input bit ed, input bit ec, input string req);
        inject_val = s;
        @(negedge clk);
        chk(rx_data == ed, req, rx_data, ed);
        chk(rx_clk == ec, req, rx_clk, ec);
    endtask

    initial begin
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 4; p++)
                run_stream(m[0], p, 40);
        do_reset(1'b0);
        inject = 1'b1;
        inject_sym(2'b10, 1'b0, 1'b0, "R6 unused code");
        inject_sym(2'b11, 1'b0, 1'b1, "R6 negative symbol");
        inject_sym(2'b01, 1'b1, 1'b1, "R6 positive symbol");
        inject_sym(2'b00, 1'b0, 1'b0, "R6 zero symbol");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule